// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects system-management events into a latched status register and gates them with a read-write mask register. Each event is a single-cycle pulse. It sets its own status bit, and that bit stays set until software reads the status register. Any set bit whose mask bit is 1 pulls the active-low host interrupt low. When the local bus runs in configuration mode, the same unmasked frame-alignment, BERT, system-error and parity bits also pull the active-low local interrupt low.

In bridge mode the local bus is a downstream target. Two extra sources apply there. The first is the local interrupt pin, which is an input in this mode. The second is a built-in access timer. It watches each local access and flags an aborted access when the active-low ready strobe does not arrive in time. In configuration mode neither source has meaning, so both of their status bits are held at zero.

Top module: `irq_status_ctrl`

## Requirements
- R1: Both registers reset to 0. A mask write stores the data, but only bits 0 to 4, 14 and 15 are kept. Every other mask bit reads 0, so writing 0xFFFF reads back 0xC01F. A mask bit of 1 enables its source and a mask bit of 0 blocks it.
- R2: An event pulse sets its status bit one clock edge later. The bit positions are: bit 0 receive frame-alignment change, bit 1 transmit frame-alignment change, bit 2 BERT state change, bit 3 system error, bit 4 parity error.
- R3: A read (stat_rd high at an edge) returns the register value through stat_rdata during that cycle. After the edge, every bit without a new event is 0.
- R4: An event in the same cycle as a read leaves its bit set after the edge. The read still returns the value held before that edge.
- R5: host_irq_n is a level output. It is 0 exactly when some status bit and its mask bit are both 1, and it returns to 1 once every unmasked bit is clear.
- R6: local_irq_n is 0 only in configuration mode (cfg_mode=1), and only when some unmasked status bit among bits 0 to 4 is set. In bridge mode it stays 1.
- R7: In bridge mode, a low lcl_int_n at an edge sets status bit 15. That bit can drive host_irq_n but never local_irq_n.
- R8: In bridge mode, acc_start at an edge starts an access. If lcl_rdy_n is still high at the ninth edge after the start, status bit 14 is set at that edge. A low lcl_rdy_n at any of those nine edges ends the access with no error.
- R9: A timed-out access sets bit 14 only once. After a read clears it, the bit stays 0 until a new access times out.
- R10: While cfg_mode is 1, status bits 14 and 15 are held at 0. Neither the timer nor lcl_int_n can set them, and a bit set earlier is cleared at the first edge in configuration mode.
- R11: Status bits 5 to 13 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the local clock for the access timer |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 1 = configuration mode, 0 = bridge mode |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | Mask write data |
| mask_q | output | 16 | Current mask register value |
| stat_rd | input | 1 | Status read strobe; clears on the edge |
| stat_rdata | output | 16 | Current status register value |
| ev_rx_align | input | 1 | Receive frame-alignment change pulse |
| ev_tx_align | input | 1 | Transmit frame-alignment change pulse |
| ev_bert | input | 1 | BERT state change pulse |
| ev_sys_err | input | 1 | System error pulse |
| ev_par_err | input | 1 | Parity error pulse |
| lcl_int_n | input | 1 | Active-low local interrupt pin (bridge mode) |
| acc_start | input | 1 | Local access start pulse |
| lcl_rdy_n | input | 1 | Active-low local ready strobe |
| host_irq_n | output | 1 | Active-low host interrupt |
| local_irq_n | output | 1 | Active-low local interrupt |

## Verification
Every status bit changes at the first clock edge after its event, read or lcl_int_n sample. Both interrupt outputs follow the registers with no further delay. Read data shows the register before the clearing edge, and a timeout lands on exactly the ninth edge after the start edge. The bench therefore drives inputs on falling edges and checks on the next falling edge. It reads stat_rdata during the read cycle itself, and it checks the timeout after the eighth edge, when bit 14 must still be 0, and again after the ninth, when it must be 1.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int W       = 16,
  parameter int TIMEOUT = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_mode,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] mask_q,
  input  logic         stat_rd,
  output logic [W-1:0] stat_rdata,
  input  logic         ev_rx_align,
  input  logic         ev_tx_align,
  input  logic         ev_bert,
  input  logic         ev_sys_err,
  input  logic         ev_par_err,
  input  logic         lcl_int_n,
  input  logic         acc_start,
  input  logic         lcl_rdy_n,
  output logic         host_irq_n,
  output logic         local_irq_n
);
  localparam int B_LBE   = 14;
  localparam int B_LBINT = 15;
  localparam int CW      = $clog2(TIMEOUT + 1);
  localparam logic [W-1:0] CORE_BITS = W'(16'h001F);
  localparam logic [W-1:0] LB_BITS   = W'(1) << B_LBE | W'(1) << B_LBINT;
  localparam logic [W-1:0] USED      = CORE_BITS | LB_BITS;

  logic [W-1:0]  stat, mask, set_v, stat_nxt;
  logic [CW-1:0] cnt;
  logic          acc_active, tmo_fire;

  assign tmo_fire = !cfg_mode && acc_active && !acc_start && lcl_rdy_n
                    && cnt == CW'(TIMEOUT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_active <= 1'b0;
      cnt        <= '0;
    end else if (cfg_mode) begin
      acc_active <= 1'b0;
    end else if (acc_start) begin
      acc_active <= 1'b1;
      cnt        <= '0;
    end else if (acc_active) begin
      if (!lcl_rdy_n || tmo_fire) acc_active <= 1'b0;
      else                        cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    set_v          = '0;
    set_v[0]       = ev_rx_align;
    set_v[1]       = ev_tx_align;
    set_v[2]       = ev_bert;
    set_v[3]       = ev_sys_err;
    set_v[4]       = ev_par_err;
    set_v[B_LBE]   = tmo_fire;
    set_v[B_LBINT] = !cfg_mode && !lcl_int_n;
    stat_nxt = ((stat & ~{W{stat_rd}}) | set_v) & USED;
    if (cfg_mode) stat_nxt = stat_nxt & ~LB_BITS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= stat_nxt;
      if (mask_we) mask <= mask_wdata & USED;
    end
  end

  assign mask_q      = mask;
  assign stat_rdata  = stat;
  assign host_irq_n  = ~|(stat & mask);
  assign local_irq_n = ~(cfg_mode && |(stat & mask & CORE_BITS));

  // R1
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == ($past(mask_wdata) & USED));
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_par_err |=> stat_rdata[4]);
  // R3
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !ev_rx_align |=> !stat_rdata[0]);
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> stat_rdata[B_LBINT:B_LBE] == 2'b00);
  // R6
  local_implies_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !local_irq_n |-> !host_irq_n);
  // R9
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> !acc_active);
  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[13:5] == '0);
endmodule

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
  logic clk = 0, rst_n = 0, cfg_mode = 0, mask_we = 0, stat_rd = 0;
  logic [15:0] mask_wdata = '0, mask_q, stat_rdata;
  logic ev_rx = 0, ev_tx = 0, ev_bert = 0, ev_sys = 0, ev_par = 0;
  logic lcl_int_n = 1, acc_start = 0, lcl_rdy_n = 1, host_irq_n, local_irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .mask_q(mask_q), .stat_rd(stat_rd),
    .stat_rdata(stat_rdata), .ev_rx_align(ev_rx), .ev_tx_align(ev_tx),
    .ev_bert(ev_bert), .ev_sys_err(ev_sys), .ev_par_err(ev_par),
    .lcl_int_n(lcl_int_n), .acc_start(acc_start), .lcl_rdy_n(lcl_rdy_n),
    .host_irq_n(host_irq_n), .local_irq_n(local_irq_n));

  // {mask[4:0], events[4:0], cfg, exp host_irq_n, exp local_irq_n}
  // event bits: 0 rx, 1 tx, 2 bert, 3 sys, 4 par
  localparam logic [12:0] VEC [0:7] = '{
    {5'b00001, 5'b00001, 1'b0, 1'b0, 1'b1},
    {5'b00001, 5'b00001, 1'b1, 1'b0, 1'b0},
    {5'b00010, 5'b00001, 1'b1, 1'b1, 1'b1},
    {5'b11111, 5'b10000, 1'b1, 1'b0, 1'b0},
    {5'b10000, 5'b01111, 1'b0, 1'b1, 1'b1},
    {5'b01000, 5'b01000, 1'b0, 1'b0, 1'b1},
    {5'b00100, 5'b00110, 1'b1, 1'b0, 1'b0},
    {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic set_ev(input logic [4:0] e);
    {ev_par, ev_sys, ev_bert, ev_tx, ev_rx} = e;
  endtask

  task automatic wr_mask(input logic [15:0] m);
    mask_we = 1; mask_wdata = m; step(); mask_we = 0;
  endtask

  task automatic clr(); stat_rd = 1; step(); stat_rd = 0; endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    chk("R1 reset mask", mask_q, 16'h0000);
    chk("R1 reset status", stat_rdata, 16'h0000);
    chk("R5 reset host", {15'd0, host_irq_n}, 16'h0001);
    chk("R6 reset local", {15'd0, local_irq_n}, 16'h0001);

    wr_mask(16'hFFFF);
    chk("R1 unused mask bits", mask_q, 16'hC01F);

    for (int i = 0; i < 8; i++) begin
      cfg_mode = VEC[i][2]; mask_we = 1; mask_wdata = {11'd0, VEC[i][12:8]}; stat_rd = 1;
      step();
      mask_we = 0; stat_rd = 0; set_ev(VEC[i][7:3]);
      step();
      set_ev(5'b0);
      chk("R2 status bits", stat_rdata, {11'd0, VEC[i][7:3]});
      chk("R5 host level", {15'd0, host_irq_n}, {15'd0, VEC[i][1]});
      chk("R6 local routing", {15'd0, local_irq_n}, {15'd0, VEC[i][0]});
    end

    cfg_mode = 0; clr(); wr_mask(16'h0010);
    set_ev(5'b10000); step(); set_ev(5'b0);
    stat_rd = 1;
    chk("R3 read value", stat_rdata, 16'h0010);
    step(); stat_rd = 0;
    chk("R3 cleared", stat_rdata, 16'h0000);
    chk("R5 deassert", {15'd0, host_irq_n}, 16'h0001);

    set_ev(5'b00001); step(); set_ev(5'b0);
    set_ev(5'b00001); stat_rd = 1;
    chk("R4 read returns old", stat_rdata, 16'h0001);
    step(); set_ev(5'b0); stat_rd = 0;
    chk("R4 set wins", stat_rdata, 16'h0001);
    clr();

    set_ev(5'b11111); lcl_int_n = 0; step(); set_ev(5'b0); lcl_int_n = 1;
    chk("R11 unused status zero", stat_rdata & 16'h3FE0, 16'h0000);
    clr();

    wr_mask(16'h8000);
    lcl_int_n = 0; step(); lcl_int_n = 1;
    chk("R7 local int status", stat_rdata, 16'h8000);
    chk("R7 host driven", {15'd0, host_irq_n}, 16'h0000);
    chk("R7 local not driven", {15'd0, local_irq_n}, 16'h0001);
    cfg_mode = 1; step();
    chk("R10 cleared in cfg", stat_rdata, 16'h0000);
    lcl_int_n = 0; step(); lcl_int_n = 1;
    chk("R10 lcl int ignored", stat_rdata, 16'h0000);
    chk("R10 no host irq", {15'd0, host_irq_n}, 16'h0001);
    acc_start = 1; step(); acc_start = 0;
    for (int k = 0; k < 12; k++) step();
    chk("R10 no timeout in cfg", stat_rdata, 16'h0000);

    cfg_mode = 0; wr_mask(16'h4000); clr();
    acc_start = 1; step(); acc_start = 0;
    for (int k = 1; k < 9; k++) step();
    chk("R8 not yet at edge 8", stat_rdata, 16'h0000);
    step();
    chk("R8 timeout at edge 9", stat_rdata, 16'h4000);
    chk("R8 host irq", {15'd0, host_irq_n}, 16'h0000);
    clr();
    for (int k = 0; k < 20; k++) step();
    chk("R9 fires once", stat_rdata, 16'h0000);

    acc_start = 1; step(); acc_start = 0;
    for (int k = 1; k < 9; k++) step();
    lcl_rdy_n = 0; step(); lcl_rdy_n = 1;
    for (int k = 0; k < 5; k++) step();
    chk("R8 ready at edge 9 no error", stat_rdata, 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule